// File: doc/BRIEF.md
# DDR2 Command Spacing Guard

This block sits between a memory controller's command scheduler and the DRAM command bus. Each clock the scheduler may offer one command (no-operation, activate, read, write or precharge) together with a bank number. The guard accepts the command only once every spacing rule that applies to it is met. Until then it holds the offer back and puts a no-operation on the bus.

The spacing values are derived from posted-CAS latency relationships rather than from fixed counters. Read latency is the additive latency plus the CAS latency. Write latency is one clock less than read latency. A write blocks any later read for (CL - 1) + BL/2 + tWTR clocks. A write blocks a precharge of its own bank until tWR clocks after its data burst has ended. A precharge blocks an activate of the same bank for tRP clocks. The guard also raises a write-data enable for the clocks in which the burst's data must be driven.

The latency and timing values are run-time inputs. They are taken up only while no timer is running and no write burst is pending.

Top module: `ddr2_cmd_guard`

## Requirements
- R1: After reset, the guard is ready for a READ, a PRECHARGE or an ACTIVATE to any bank. With no offer present, `cmd_out` shows NOP and `wdata_en` is low.
- R2: Command codes are NOP=0, ACTIVATE=1, READ=2, WRITE=3, PRECHARGE=4. An accepted offer (`req_valid` and `req_ready` both high) appears on `cmd_out`/`cmd_bank` in the same cycle. While an offer is held back, `cmd_out` is NOP.
- R3: A READ to any bank is accepted no earlier than (CL - 1) + BL/2 + tWTR clock edges after the last accepted WRITE. With AL=2, CL=3, tWTR=2 and BL=4 this is 6 edges.
- R4: A new WRITE restarts the write-to-read window, even if the previous window has not yet expired.
- R5: A PRECHARGE to a bank is accepted no earlier than WL + BL/2 + tWR edges after the last WRITE to that bank, where WL = AL + CL - 1. A PRECHARGE to another bank is not delayed.
- R6: An ACTIVATE to a bank is accepted no earlier than tRP edges after that bank's PRECHARGE. An ACTIVATE to another bank is not delayed.
- R7: `wdata_en` is high for exactly BL/2 clocks, beginning WL clock edges after the edge on which the WRITE was accepted.
- R8: The configuration inputs take effect only while the guard is idle (all timers at zero, no burst pending). Changes made while the guard is busy do not alter the spacing already in force.
- R9: A WRITE is never held back, and the write-to-read window does not delay ACTIVATE or WRITE commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_al | input | 4 | Additive latency in clocks |
| cfg_cl | input | 4 | CAS latency in clocks |
| cfg_twtr | input | 4 | Write-to-read turnaround in clocks |
| cfg_twr | input | 4 | Write recovery in clocks |
| cfg_trp | input | 4 | Precharge period in clocks |
| req_valid | input | 1 | Scheduler offers a command |
| req_cmd | input | 3 | Offered command code |
| req_bank | input | 2 | Offered bank |
| req_ready | output | 1 | Offer accepted this cycle when valid |
| cmd_out | output | 3 | Command on the DRAM bus |
| cmd_bank | output | 2 | Bank on the DRAM bus |
| wdata_en | output | 1 | Write data must be driven this clock |

## Verification
The bench issues a read immediately after a write and measures the edge on which the read is let through. A guard that built the gap from the read latency or left out tWTR would accept the read early or late. A second write is placed inside a running window, which catches a timer that keeps counting from the first write rather than restarting. Precharges and activates go alternately to a busy bank and to an idle bank, which exposes per-bank timers that are shared between banks or indexed wrongly. The configuration is changed in the middle of a busy period and again after the guard goes idle, which catches latching at the wrong time. The write-data window is checked one clock on each side of its edges, which catches off-by-one errors in the write latency.

// File: rtl/ddr2_guard_pkg.sv
// Package: shared command encoding for the DDR2 command spacing guard.
// Assumes a 3-bit command field on both the scheduler side and the bus side.
package ddr2_guard_pkg;
    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4
    } ddr2_cmd_e;
endpackage

// File: rtl/ddr2_lat_calc.sv
// Module: ddr2_lat_calc
// Turns the configured latencies into write latency and the reload values of
// the spacing timers. A timer loaded with N-1 on the issuing edge lets the
// dependent command through N edges later.
// Assumes CL >= 1 and BURST_LEN >= 2, so the write-to-read gap is at least 1.
module ddr2_lat_calc #(
    parameter int CFG_W     = 4,
    parameter int CNT_W     = 7,
    parameter int BURST_LEN = 4
) (
    input  logic [CFG_W-1:0] al,
    input  logic [CFG_W-1:0] cl,
    input  logic [CFG_W-1:0] twtr,
    input  logic [CFG_W-1:0] twr,
    input  logic [CFG_W-1:0] trp,
    output logic [CNT_W-1:0] wl,
    output logic [CNT_W-1:0] wtr_load,
    output logic [CNT_W-1:0] wr_load,
    output logic [CNT_W-1:0] rp_load
);
    localparam int HALF = BURST_LEN / 2;
    localparam logic [CNT_W-1:0] HALF_C = CNT_W'(HALF);

    logic [CNT_W-1:0] rl;
    logic [CNT_W-1:0] wtr_gap;
    logic [CNT_W-1:0] wr_gap;

    // Derive read and write latency, then the three gaps as reload values.
    always_comb begin
        rl       = CNT_W'(al) + CNT_W'(cl);
        wl       = (rl == '0) ? '0 : rl - 1'b1;
        wtr_gap  = ((cl == '0) ? '0 : CNT_W'(cl) - 1'b1) + HALF_C + CNT_W'(twtr);
        wr_gap   = wl + HALF_C + CNT_W'(twr);
        wtr_load = (wtr_gap == '0) ? '0 : wtr_gap - 1'b1;
        wr_load  = (wr_gap == '0) ? '0 : wr_gap - 1'b1;
        rp_load  = (trp == '0) ? '0 : CNT_W'(trp) - 1'b1;
    end
endmodule

// File: rtl/ddr2_bank_timers.sv
// Module: ddr2_bank_timers
// One write-recovery timer and one precharge timer per bank. Each timer
// saturates at zero. A write to a bank reloads that bank's recovery timer,
// and a precharge reloads that bank's precharge timer.
// Assumes at most one command fires per clock.
module ddr2_bank_timers #(
    parameter int NUM_BANKS = 4,
    parameter int BANK_W    = 2,
    parameter int CNT_W     = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_fire,
    input  logic                 pre_fire,
    input  logic [BANK_W-1:0]    bank,
    input  logic [CNT_W-1:0]     wr_load,
    input  logic [CNT_W-1:0]     rp_load,
    output logic [NUM_BANKS-1:0] wr_busy,
    output logic [NUM_BANKS-1:0] rp_busy,
    output logic                 any_busy
);
    genvar b;
    generate
        for (b = 0; b < NUM_BANKS; b++) begin : g_bank
            logic [CNT_W-1:0] wr_cnt;
            logic [CNT_W-1:0] rp_cnt;
            logic             hit;

            assign hit = (bank == BANK_W'(b));

            // Write-recovery countdown for this bank.
            always_ff @(posedge clk) begin
                if (!rst_n)                wr_cnt <= '0;
                else if (wr_fire && hit)   wr_cnt <= wr_load;
                else if (wr_cnt != '0)     wr_cnt <= wr_cnt - 1'b1;
            end

            // Precharge-period countdown for this bank.
            always_ff @(posedge clk) begin
                if (!rst_n)                rp_cnt <= '0;
                else if (pre_fire && hit)  rp_cnt <= rp_load;
                else if (rp_cnt != '0)     rp_cnt <= rp_cnt - 1'b1;
            end

            assign wr_busy[b] = (wr_cnt != '0);
            assign rp_busy[b] = (rp_cnt != '0);
        end
    endgenerate

    assign any_busy = (|wr_busy) | (|rp_busy);
endmodule

// File: rtl/ddr2_wdata_sched.sv
// Module: ddr2_wdata_sched
// Schedules the write-data enable. On each accepted write it sets the bits
// WL..WL+HALF-1 of a shift register that moves one place toward bit 0 every
// clock, so bit 0 is high during the clocks of the write burst.
// Assumes WL + HALF fits in DEPTH.
module ddr2_wdata_sched #(
    parameter int DEPTH = 32,
    parameter int CNT_W = 7,
    parameter int HALF  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_fire,
    input  logic [CNT_W-1:0] wl,
    output logic             wdata_en,
    output logic             pending
);
    logic [DEPTH-1:0] sched;
    logic [DEPTH-1:0] mask;

    // Build the burst window that a new write adds.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mask[i] = (i >= int'(wl)) && (i < int'(wl) + HALF);
        end
    end

    // Shift the schedule toward bit 0 and merge in any new burst.
    always_ff @(posedge clk) begin
        if (!rst_n) sched <= '0;
        else        sched <= {1'b0, sched[DEPTH-1:1]} | (wr_fire ? mask : '0);
    end

    assign wdata_en = sched[0];
    assign pending  = |sched;
endmodule

// File: rtl/ddr2_cmd_guard.sv
// Module: ddr2_cmd_guard (top)
// Holds back each scheduler command until its spacing rules are met. These
// are write-to-read (a single timer for all banks), write recovery before
// precharge (per bank) and the precharge period before activate (per bank).
// It also drives the write-data enable. The configuration is captured while
// the guard is idle and held until it is idle again.
// Assumes the scheduler keeps an offer stable until it is accepted.
module ddr2_cmd_guard
    import ddr2_guard_pkg::*;
#(
    parameter int CFG_W     = 4,
    parameter int NUM_BANKS = 4,
    parameter int BURST_LEN = 4,
    parameter int BANK_W    = $clog2(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CFG_W-1:0]  cfg_al,
    input  logic [CFG_W-1:0]  cfg_cl,
    input  logic [CFG_W-1:0]  cfg_twtr,
    input  logic [CFG_W-1:0]  cfg_twr,
    input  logic [CFG_W-1:0]  cfg_trp,
    input  logic              req_valid,
    input  logic [2:0]        req_cmd,
    input  logic [BANK_W-1:0] req_bank,
    output logic              req_ready,
    output logic [2:0]        cmd_out,
    output logic [BANK_W-1:0] cmd_bank,
    output logic              wdata_en
);
    localparam int CNT_W = CFG_W + 3;
    localparam int HALF  = BURST_LEN / 2;
    localparam int DEPTH = 2 * ((1 << CFG_W) - 1) + HALF;

    ddr2_cmd_e        cmd_in;
    logic             fire;
    logic             wr_fire;
    logic             pre_fire;
    logic             idle;
    logic             any_busy;
    logic             pending;
    logic [NUM_BANKS-1:0] wr_busy;
    logic [NUM_BANKS-1:0] rp_busy;
    logic [CNT_W-1:0] wtr_cnt;
    logic [CNT_W-1:0] wl;
    logic [CNT_W-1:0] wtr_load;
    logic [CNT_W-1:0] wr_load;
    logic [CNT_W-1:0] rp_load;

    logic [CFG_W-1:0] al_q, cl_q, twtr_q, twr_q, trp_q;
    logic [CFG_W-1:0] al_a, cl_a, twtr_a, twr_a, trp_a;

    assign cmd_in = ddr2_cmd_e'(req_cmd);
    assign idle   = (wtr_cnt == '0) && !any_busy && !pending;

    // Capture the configuration on every idle clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            al_q <= '0; cl_q <= '0; twtr_q <= '0; twr_q <= '0; trp_q <= '0;
        end else if (idle) begin
            al_q <= cfg_al; cl_q <= cfg_cl; twtr_q <= cfg_twtr;
            twr_q <= cfg_twr; trp_q <= cfg_trp;
        end
    end

    // Live inputs while idle, otherwise the held copy.
    always_comb begin
        al_a   = idle ? cfg_al   : al_q;
        cl_a   = idle ? cfg_cl   : cl_q;
        twtr_a = idle ? cfg_twtr : twtr_q;
        twr_a  = idle ? cfg_twr  : twr_q;
        trp_a  = idle ? cfg_trp  : trp_q;
    end

    ddr2_lat_calc #(.CFG_W(CFG_W), .CNT_W(CNT_W), .BURST_LEN(BURST_LEN)) lat_i (
        .al(al_a), .cl(cl_a), .twtr(twtr_a), .twr(twr_a), .trp(trp_a),
        .wl(wl), .wtr_load(wtr_load), .wr_load(wr_load), .rp_load(rp_load)
    );

    // Readiness: only the rule that applies to the offered command can block.
    always_comb begin
        unique case (cmd_in)
            CMD_RD:  req_ready = (wtr_cnt == '0);
            CMD_PRE: req_ready = !wr_busy[req_bank];
            CMD_ACT: req_ready = !rp_busy[req_bank];
            default: req_ready = 1'b1;
        endcase
    end

    assign fire     = req_valid && req_ready;
    assign wr_fire  = fire && (cmd_in == CMD_WR);
    assign pre_fire = fire && (cmd_in == CMD_PRE);
    assign cmd_out  = fire ? req_cmd : 3'(CMD_NOP);
    assign cmd_bank = fire ? req_bank : '0;

    // Write-to-read countdown, shared by all banks, restarted by every write.
    always_ff @(posedge clk) begin
        if (!rst_n)             wtr_cnt <= '0;
        else if (wr_fire)       wtr_cnt <= wtr_load;
        else if (wtr_cnt != '0) wtr_cnt <= wtr_cnt - 1'b1;
    end

    ddr2_bank_timers #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .CNT_W(CNT_W)) banks_i (
        .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .pre_fire(pre_fire),
        .bank(req_bank), .wr_load(wr_load), .rp_load(rp_load),
        .wr_busy(wr_busy), .rp_busy(rp_busy), .any_busy(any_busy)
    );

    ddr2_wdata_sched #(.DEPTH(DEPTH), .CNT_W(CNT_W), .HALF(HALF)) wsched_i (
        .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .wl(wl),
        .wdata_en(wdata_en), .pending(pending)
    );
endmodule

// File: rtl/ddr2_cmd_guard_chk.sv
// Module: ddr2_cmd_guard_chk
// Checker bound into the guard. It watches the handshake, the command bus
// and the write-data enable. Assumes BURST_LEN = 4 and CL >= 1.
module ddr2_cmd_guard_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic [2:0] req_cmd,
    input logic       req_ready,
    input logic [2:0] cmd_out,
    input logic       wdata_en
);
    // R2: a held-back offer leaves NOP on the bus.
    a_r2_stall_nop: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |-> (cmd_out == 3'd0));

    // R2: an accepted offer is passed through unchanged.
    a_r2_accept_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |-> (cmd_out == req_cmd));

    // R3: a read never follows a write on the very next clock.
    a_r3_no_back_to_back_rd: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_out == 3'd3) |=> (cmd_out != 3'd2));

    // R7: the write-data window lasts at least two clocks.
    a_r7_burst_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdata_en) |=> wdata_en);

    // R9: a write offer is never held back.
    a_r9_write_free: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_cmd == 3'd3) |-> req_ready);
endmodule

bind ddr2_cmd_guard ddr2_cmd_guard_chk chk_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
    .req_ready(req_ready), .cmd_out(cmd_out), .wdata_en(wdata_en)
);

// File: tb/ddr2_cmd_guard_tb.sv
// Directed bench for the command spacing guard: one task per scenario.
module ddr2_cmd_guard_tb_top;
    localparam int CLK_P = 10;
    localparam logic [2:0] NOP = 3'd0, ACT = 3'd1, RD = 3'd2, WR = 3'd3, PRE = 3'd4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] cfg_al = 4'd2, cfg_cl = 4'd3, cfg_twtr = 4'd2, cfg_twr = 4'd3, cfg_trp = 4'd5;
    logic       req_valid = 1'b0;
    logic [2:0] req_cmd = 3'd0;
    logic [1:0] req_bank = 2'd0;
    logic       req_ready;
    logic [2:0] cmd_out;
    logic [1:0] cmd_bank;
    logic       wdata_en;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    logic hist [0:8191];

    ddr2_cmd_guard dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_al(cfg_al), .cfg_cl(cfg_cl),
        .cfg_twtr(cfg_twtr), .cfg_twr(cfg_twr), .cfg_trp(cfg_trp),
        .req_valid(req_valid), .req_cmd(req_cmd), .req_bank(req_bank),
        .req_ready(req_ready), .cmd_out(cmd_out), .cmd_bank(cmd_bank),
        .wdata_en(wdata_en)
    );

    always #(CLK_P/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) hist[cyc % 8192] = wdata_en;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Offer one command and return the edge index on which it was accepted.
    task automatic send(input logic [2:0] c, input logic [1:0] b, output int e);
        int waits = 0;
        @(negedge clk);
        req_valid = 1'b1; req_cmd = c; req_bank = b;
        #1;
        while (!req_ready && waits < 500) begin
            chk(cmd_out == NOP, "R2 stall shows NOP", cmd_out, NOP);
            @(negedge clk); #1;
            waits++;
        end
        chk(cmd_out == c && cmd_bank == b, "R2 pass-through", cmd_out, c);
        e = cyc + 1;
        @(posedge clk); #1;
        req_valid = 1'b0; req_cmd = NOP; req_bank = 2'd0;
    endtask

    task automatic chk_burst(input int e_w, input int wl, input string req);
        chk(hist[(e_w + wl - 1) % 8192] == 1'b0, req, hist[(e_w + wl - 1) % 8192], 0);
        chk(hist[(e_w + wl) % 8192] == 1'b1, req, hist[(e_w + wl) % 8192], 1);
        chk(hist[(e_w + wl + 1) % 8192] == 1'b1, req, hist[(e_w + wl + 1) % 8192], 1);
        chk(hist[(e_w + wl + 2) % 8192] == 1'b0, req, hist[(e_w + wl + 2) % 8192], 0);
    endtask

    task automatic t_reset;
        @(negedge clk); #1;
        chk(cmd_out == NOP, "R1 idle bus NOP", cmd_out, NOP);
        chk(wdata_en == 1'b0, "R1 wdata_en low", wdata_en, 0);
        req_valid = 1'b1; req_bank = 2'd2;
        req_cmd = RD;  #1; chk(req_ready, "R1 read ready", req_ready, 1);
        req_cmd = PRE; #1; chk(req_ready, "R1 precharge ready", req_ready, 1);
        req_cmd = ACT; #1; chk(req_ready, "R1 activate ready", req_ready, 1);
        req_valid = 1'b0; req_cmd = NOP; req_bank = 2'd0;
    endtask

    task automatic t_wtr;
        int ew, er;
        send(WR, 2'd0, ew);
        send(RD, 2'd1, er);
        chk(er - ew == 6, "R3 write-to-read gap", er - ew, 6);
        idle(2);
        chk_burst(ew, 4, "R7 write data window WL=4");
        idle(30);
    endtask

    task automatic t_reload;
        int e1, e2, er;
        send(WR, 2'd0, e1);
        idle(3);
        send(WR, 2'd0, e2);
        send(RD, 2'd0, er);
        chk(er - e2 == 6, "R4 window restarted by second write", er - e2, 6);
        idle(30);
    endtask

    task automatic t_bank;
        int ew, ep1, ep2, ea3, ea2;
        send(WR, 2'd2, ew);
        send(PRE, 2'd1, ep1);
        chk(ep1 - ew == 1, "R5 other bank precharge free", ep1 - ew, 1);
        send(PRE, 2'd2, ep2);
        chk(ep2 - ew == 9, "R5 write recovery gap", ep2 - ew, 9);
        send(ACT, 2'd3, ea3);
        chk(ea3 - ep2 == 1, "R6 other bank activate free", ea3 - ep2, 1);
        send(ACT, 2'd2, ea2);
        chk(ea2 - ep2 == 5, "R6 precharge period gap", ea2 - ep2, 5);
        idle(30);
    endtask

    task automatic t_cfg;
        int ew, er;
        send(WR, 2'd1, ew);
        cfg_cl = 4'd9; cfg_twtr = 4'd7;
        send(RD, 2'd1, er);
        chk(er - ew == 6, "R8 busy config change ignored", er - ew, 6);
        idle(40);
        cfg_al = 4'd0; cfg_cl = 4'd4; cfg_twtr = 4'd3;
        send(WR, 2'd0, ew);
        send(RD, 2'd0, er);
        chk(er - ew == 8, "R8 idle config applied (R3 gap 8)", er - ew, 8);
        idle(2);
        chk_burst(ew, 3, "R7 write data window WL=3");
        idle(40);
        cfg_al = 4'd2; cfg_cl = 4'd3; cfg_twtr = 4'd2;
        idle(2);
    endtask

    task automatic t_free;
        int e1, e2, ea, er;
        send(WR, 2'd0, e1);
        send(WR, 2'd1, e2);
        chk(e2 - e1 == 1, "R9 write not held", e2 - e1, 1);
        send(ACT, 2'd3, ea);
        chk(ea - e2 == 1, "R9 activate not held by write window", ea - e2, 1);
        send(RD, 2'd3, er);
        chk(er - e2 == 6, "R9/R3 read waits on latest write", er - e2, 6);
        idle(30);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_wtr;
        t_reload;
        t_bank;
        t_cfg;
        t_free;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_P * 100000);
        errors++; checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule